// File: doc/BRIEF.md
# USB Packet Write Gate

This block sits between a USB-side parallel word interface and a signal-processing clock domain. Each cycle in which the write strobe is high carries one 16-bit word. The host always sends fixed packets of 256 words, but the strobe stays high for one extra cycle after the last real word of a packet, and that cycle carries no valid data. A 9-bit per-packet counter follows the strobe cycles. Its top bit blocks the write request, so the extra cycle never reaches the storage.

Accepted words go into a 2048 x 16 dual-clock FIFO. Writes happen on the USB clock and reads happen on the processing clock. The two pointers cross between the domains as Gray code through two-flop synchronisers. A have-space flag on the USB side tells the producer whether a whole packet still fits.

Top module: `usb_pkt_wr_gate`

## Requirements
- R1: The packet counter advances by one on each USB clock cycle in which the strobe is high and the counter is below 256. It holds its value on a strobe-low cycle below 256, so idle cycles inside a packet do not count.
- R2: A word is written only when the strobe is high and the counter is not 256, which means bit 8 of the counter is clear. The strobe cycle that arrives while the counter holds 256 writes nothing.
- R3: When the counter holds 256, it returns to 0 on the next USB clock edge, whether the strobe is high or low. The following packet therefore starts counting at 0.
- R4: have_space is a registered flag in the USB domain. It is 1 exactly when at least 256 entries are free, measured against the synchronised read pointer. With 1792 words stored it is 1, and with 2048 words stored it is 0.
- R5: A write attempted while the FIFO holds 2048 words is discarded. It does not overwrite stored data and does not appear on the read side.
- R6: When rd_en is high and rd_empty is low at a processing clock edge, one word is popped, and it appears on rd_data after that edge. Words come out in the order they were written. rd_en has no effect while rd_empty is high.
- R7: The storage holds 2048 words of 16 bits. Pointers cross clock domains as Gray code through two-flop synchronisers, so rd_empty falls only a few processing cycles after a write.
- R8: Each domain has a synchronous reset. usb_rst clears the counter and the write pointer and sets have_space to 1. dsp_rst clears the read pointer and sets rd_empty to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| usb_clk | input | 1 | USB-side clock |
| usb_rst | input | 1 | Synchronous reset, USB domain |
| wr_strobe | input | 1 | Word strobe from the USB interface |
| wr_data | input | 16 | Word that goes with the strobe |
| have_space | output | 1 | 1 when a full packet still fits |
| dsp_clk | input | 1 | Processing-side clock |
| dsp_rst | input | 1 | Synchronous reset, processing domain |
| rd_en | input | 1 | Pop request |
| rd_data | output | 16 | Popped word, valid after the pop edge |
| rd_empty | output | 1 | 1 when no word is readable |

## Verification
The bench targets four behaviours:

- **Extra strobe cycle with a marker value.** Each packet ends with the extra strobe cycle carrying a marker value. A gate that lets this cycle through puts an unexpected word into the read stream.
- **Idle cycle inside a packet, and a packet with no trailing strobe.** A counter that advanced on the idle cycle, or that stayed at 256, would drop a real word from the start or end of a packet.
- **Filling to exactly 1792 and then 2048 words.** This checks the have_space threshold on both sides. A further packet is then pushed into the full FIFO; an overwrite would corrupt the drained order.
- **Popping while empty.** The bench holds rd_en high while the FIFO is empty. A read pointer that moved in that state would shift every later word.

// File: rtl/usb_wg_pkg.sv
package usb_wg_pkg;
    localparam int unsigned WG_DATA_W    = 16;
    localparam int unsigned WG_ADDR_W    = 11;
    localparam int unsigned WG_PKT_WORDS = 256;
    localparam int unsigned WG_SYNC_LEN  = 2;
endpackage

// File: rtl/usb_wg_counter.sv
// Per-packet strobe counter; its top bit masks the trailing strobe cycle.
// PKT_WORDS must be a power of two.
module usb_wg_counter #(
    parameter int unsigned PKT_WORDS = usb_wg_pkg::WG_PKT_WORDS,
    localparam int unsigned CNT_W    = $clog2(PKT_WORDS) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic             fifo_full,
    output logic             fifo_wr,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic       tail;

    always_comb begin
        s_d  = s_q;
        tail = s_q.cnt[CNT_W-1];
        if (tail) begin
            s_d.cnt = '0;
        end else if (strobe) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        fifo_wr = strobe & ~tail & ~fifo_full;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign cnt = s_q.cnt;
endmodule

// File: rtl/usb_wg_sync.sv
// Multi-flop synchroniser for a Gray-coded pointer.
module usb_wg_sync #(
    parameter int unsigned W      = 12,
    parameter int unsigned STAGES = usb_wg_pkg::WG_SYNC_LEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stg_q <= '0;
        else     stg_q <= stg_d;
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/usb_wg_wside.sv
// Write pointer, full detection and have-space flag (USB domain).
module usb_wg_wside #(
    parameter int unsigned ADDR_W    = usb_wg_pkg::WG_ADDR_W,
    parameter int unsigned PKT_WORDS = usb_wg_pkg::WG_PKT_WORDS,
    localparam int unsigned PTR_W    = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [PTR_W-1:0]  rgray_s,
    output logic [ADDR_W-1:0] waddr,
    output logic [PTR_W-1:0]  wgray,
    output logic              full,
    output logic              have_space
);
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1) << ADDR_W;
    localparam logic [PTR_W-1:0] PKT_P   = PTR_W'(PKT_WORDS);

    typedef struct packed {
        logic [PTR_W-1:0] bin;
        logic [PTR_W-1:0] gray;
        logic             space;
    } wside_state_t;

    wside_state_t     s_d, s_q;
    logic [PTR_W-1:0] rbin_s;
    logic [PTR_W-1:0] used_d;

    function automatic logic [PTR_W-1:0] gray2bin(input logic [PTR_W-1:0] g);
        logic [PTR_W-1:0] b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    always_comb begin
        s_d      = s_q;
        rbin_s   = gray2bin(rgray_s);
        full     = ((s_q.bin - rbin_s) == DEPTH_P);
        s_d.bin  = s_q.bin + PTR_W'(wr);
        s_d.gray = s_d.bin ^ (s_d.bin >> 1);
        used_d   = s_d.bin - rbin_s;
        s_d.space = ((DEPTH_P - used_d) >= PKT_P);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '{bin: '0, gray: '0, space: 1'b1};
        else     s_q <= s_d;
    end

    assign waddr      = s_q.bin[ADDR_W-1:0];
    assign wgray      = s_q.gray;
    assign have_space = s_q.space;
endmodule

// File: rtl/usb_wg_rside.sv
// Read pointer and empty flag (processing domain).
module usb_wg_rside #(
    parameter int unsigned ADDR_W = usb_wg_pkg::WG_ADDR_W,
    localparam int unsigned PTR_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [PTR_W-1:0]  wgray_s,
    output logic [ADDR_W-1:0] raddr,
    output logic [PTR_W-1:0]  rgray,
    output logic              empty,
    output logic              rd_do
);
    typedef struct packed {
        logic [PTR_W-1:0] bin;
        logic [PTR_W-1:0] gray;
        logic             empty;
    } rside_state_t;

    rside_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        rd_do     = rd_en & ~s_q.empty;
        s_d.bin   = s_q.bin + PTR_W'(rd_do);
        s_d.gray  = s_d.bin ^ (s_d.bin >> 1);
        s_d.empty = (s_d.gray == wgray_s);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '{bin: '0, gray: '0, empty: 1'b1};
        else     s_q <= s_d;
    end

    assign raddr = s_q.bin[ADDR_W-1:0];
    assign rgray = s_q.gray;
    assign empty = s_q.empty;
endmodule

// File: rtl/usb_pkt_wr_gate.sv
// Top: gated packet writes into a dual-clock word FIFO.
module usb_pkt_wr_gate #(
    parameter int unsigned DATA_W    = usb_wg_pkg::WG_DATA_W,
    parameter int unsigned ADDR_W    = usb_wg_pkg::WG_ADDR_W,
    parameter int unsigned PKT_WORDS = usb_wg_pkg::WG_PKT_WORDS,
    parameter int unsigned SYNC_LEN  = usb_wg_pkg::WG_SYNC_LEN
) (
    input  logic              usb_clk,
    input  logic              usb_rst,
    input  logic              wr_strobe,
    input  logic [DATA_W-1:0] wr_data,
    output logic              have_space,
    input  logic              dsp_clk,
    input  logic              dsp_rst,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned PTR_W = ADDR_W + 1;
    localparam int unsigned CNT_W = $clog2(PKT_WORDS) + 1;

    logic              fifo_wr;
    logic              fifo_full;
    logic [CNT_W-1:0]  cnt_w;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [PTR_W-1:0]  wgray, wgray_s;
    logic [PTR_W-1:0]  rgray, rgray_s;
    logic              rd_do;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rd_data_d, rd_data_q;

    usb_wg_counter #(.PKT_WORDS(PKT_WORDS)) u_cnt (
        .clk       (usb_clk),
        .rst       (usb_rst),
        .strobe    (wr_strobe),
        .fifo_full (fifo_full),
        .fifo_wr   (fifo_wr),
        .cnt       (cnt_w)
    );

    usb_wg_wside #(.ADDR_W(ADDR_W), .PKT_WORDS(PKT_WORDS)) u_wside (
        .clk        (usb_clk),
        .rst        (usb_rst),
        .wr         (fifo_wr),
        .rgray_s    (rgray_s),
        .waddr      (waddr),
        .wgray      (wgray),
        .full       (fifo_full),
        .have_space (have_space)
    );

    usb_wg_sync #(.W(PTR_W), .STAGES(SYNC_LEN)) u_r2w (
        .clk (usb_clk),
        .rst (usb_rst),
        .d   (rgray),
        .q   (rgray_s)
    );

    usb_wg_sync #(.W(PTR_W), .STAGES(SYNC_LEN)) u_w2r (
        .clk (dsp_clk),
        .rst (dsp_rst),
        .d   (wgray),
        .q   (wgray_s)
    );

    usb_wg_rside #(.ADDR_W(ADDR_W)) u_rside (
        .clk     (dsp_clk),
        .rst     (dsp_rst),
        .rd_en   (rd_en),
        .wgray_s (wgray_s),
        .raddr   (raddr),
        .rgray   (rgray),
        .empty   (rd_empty),
        .rd_do   (rd_do)
    );

    always_ff @(posedge usb_clk) begin
        if (fifo_wr) mem_q[waddr] <= wr_data;
    end

    always_comb begin
        rd_data_d = rd_data_q;
        if (rd_do) rd_data_d = mem_q[raddr];
    end

    always_ff @(posedge dsp_clk) begin
        if (dsp_rst) rd_data_q <= '0;
        else         rd_data_q <= rd_data_d;
    end

    assign rd_data = rd_data_q;
endmodule

// File: rtl/usb_wg_chk.sv
// Property checker bound into the top module.
module usb_wg_chk #(
    parameter int unsigned CNT_W = 9
) (
    input logic             usb_clk,
    input logic             usb_rst,
    input logic             wr_strobe,
    input logic [CNT_W-1:0] cnt,
    input logic             fifo_wr,
    input logic             fifo_full,
    input logic             have_space,
    input logic             dsp_clk,
    input logic             dsp_rst,
    input logic             rd_empty,
    input logic             rd_do
);
    // R1
    cnt_step_chk: assert property (@(posedge usb_clk) disable iff (usb_rst)
        (wr_strobe && !cnt[CNT_W-1]) |=> (cnt == $past(cnt) + 1'b1));

    // R1
    cnt_hold_chk: assert property (@(posedge usb_clk) disable iff (usb_rst)
        (!wr_strobe && !cnt[CNT_W-1]) |=> $stable(cnt));

    // R2
    tail_drop_chk: assert property (@(posedge usb_clk) disable iff (usb_rst)
        cnt[CNT_W-1] |-> !fifo_wr);

    // R3
    cnt_wrap_chk: assert property (@(posedge usb_clk) disable iff (usb_rst)
        cnt[CNT_W-1] |=> (cnt == '0));

    // R4
    space_room_chk: assert property (@(posedge usb_clk) disable iff (usb_rst)
        have_space |-> !fifo_full);

    // R5
    no_overflow_chk: assert property (@(posedge usb_clk) disable iff (usb_rst)
        fifo_full |-> !fifo_wr);

    // R6
    no_underflow_chk: assert property (@(posedge dsp_clk) disable iff (dsp_rst)
        rd_empty |-> !rd_do);
endmodule

bind usb_pkt_wr_gate usb_wg_chk #(.CNT_W(CNT_W)) u_chk (
    .usb_clk    (usb_clk),
    .usb_rst    (usb_rst),
    .wr_strobe  (wr_strobe),
    .cnt        (cnt_w),
    .fifo_wr    (fifo_wr),
    .fifo_full  (fifo_full),
    .have_space (have_space),
    .dsp_clk    (dsp_clk),
    .dsp_rst    (dsp_rst),
    .rd_empty   (rd_empty),
    .rd_do      (rd_do)
);

// File: tb/tb_usb_pkt_wr_gate.sv
module tb_usb_pkt_wr_gate;
    logic        usb_clk = 1'b0;
    logic        dsp_clk = 1'b0;
    logic        usb_rst = 1'b1;
    logic        dsp_rst = 1'b1;
    logic        wr_strobe = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        have_space;
    logic [15:0] rd_data;
    logic        rd_empty;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q[$];
    bit rd_go = 1'b0;
    bit rd_force = 1'b0;

    always #4 usb_clk = ~usb_clk;
    always #3 dsp_clk = ~dsp_clk;

    usb_pkt_wr_gate dut (
        .usb_clk    (usb_clk),
        .usb_rst    (usb_rst),
        .wr_strobe  (wr_strobe),
        .wr_data    (wr_data),
        .have_space (have_space),
        .dsp_clk    (dsp_clk),
        .dsp_rst    (dsp_rst),
        .rd_en      (rd_en),
        .rd_data    (rd_data),
        .rd_empty   (rd_empty)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Driver: 256 words, optional idle cycle, optional trailing strobe.
    task automatic send_pkt(input logic [15:0] base, input bit tail,
                            input int gap_at, input bit store);
        for (int i = 0; i < 256; i++) begin
            if (i == gap_at) begin
                @(negedge usb_clk);
                wr_strobe = 1'b0;
                wr_data   = 16'hBEEF;
            end
            @(negedge usb_clk);
            wr_strobe = 1'b1;
            wr_data   = base + 16'(i);
            if (store) exp_q.push_back(base + 16'(i));
        end
        @(negedge usb_clk);
        if (tail) begin
            wr_strobe = 1'b1;
            wr_data   = 16'hDEAD;
        end else begin
            wr_strobe = 1'b0;
        end
        @(negedge usb_clk);
        wr_strobe = 1'b0;
    endtask

    task automatic drain();
        for (int n = 0; n < 20000 && exp_q.size() != 0; n++) @(negedge dsp_clk);
        repeat (20) @(negedge dsp_clk);
    endtask

    // Monitor: pops words and compares against the scoreboard queue.
    initial begin
        bit pend = 1'b0;
        forever begin
            @(negedge dsp_clk);
            if (pend) begin
                if (exp_q.size() == 0) begin
                    chk("R2/R5 unexpected word", 32'(rd_data), 32'hFFFF_FFFF);
                end else begin
                    chk("R2/R6 read order", 32'(rd_data), 32'(exp_q.pop_front()));
                end
                pend = 1'b0;
            end
            if (rd_force) begin
                rd_en = 1'b1;
            end else if (rd_go && !rd_empty && !dsp_rst) begin
                rd_en = 1'b1;
                pend  = 1'b1;
            end else begin
                rd_en = 1'b0;
            end
        end
    end

    initial begin
        #1_200_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (6) @(negedge usb_clk);
        usb_rst = 1'b0;
        @(negedge dsp_clk);
        dsp_rst = 1'b0;
        repeat (2) @(negedge usb_clk);
        // R8: reset state
        chk("R8 have_space after reset", 32'(have_space), 32'd1);
        chk("R8 rd_empty after reset", 32'(rd_empty), 32'd1);

        // R6: rd_en while empty must not move the read pointer
        rd_force = 1'b1;
        repeat (20) @(negedge dsp_clk);
        rd_force = 1'b0;
        chk("R6 empty after forced reads", 32'(rd_empty), 32'd1);
        rd_go = 1'b1;

        // R2: trailing strobe dropped; R1: idle cycle inside a packet
        send_pkt(16'h1000, 1'b1, -1, 1'b1);
        send_pkt(16'h2000, 1'b1, 100, 1'b1);
        // R3: no trailing strobe, next packet still starts at zero
        send_pkt(16'h3000, 1'b0, -1, 1'b1);
        send_pkt(16'h4000, 1'b1, 7, 1'b1);
        drain();
        chk("R1/R3 all packet words delivered", 32'(exp_q.size()), 32'd0);
        chk("R7 empty after drain", 32'(rd_empty), 32'd1);

        // R4/R7: fill without reading
        rd_go = 1'b0;
        repeat (10) @(negedge dsp_clk);
        for (int p = 0; p < 7; p++) send_pkt(16'(p * 256), 1'b1, -1, 1'b1);
        repeat (4) @(negedge usb_clk);
        chk("R4 have_space with 1792 stored", 32'(have_space), 32'd1);
        send_pkt(16'h0700, 1'b1, -1, 1'b1);
        repeat (4) @(negedge usb_clk);
        chk("R4 have_space with 2048 stored", 32'(have_space), 32'd0);
        chk("R7 not empty when full", 32'(rd_empty), 32'd0);

        // R5: packet into a full FIFO is discarded
        send_pkt(16'h9000, 1'b1, -1, 1'b0);
        chk("R5 have_space stays low", 32'(have_space), 32'd0);

        rd_go = 1'b1;
        drain();
        chk("R5 only stored words read back", 32'(exp_q.size()), 32'd0);
        repeat (6) @(negedge usb_clk);
        chk("R4 have_space after drain", 32'(have_space), 32'd1);
        chk("R6 rd_empty after drain", 32'(rd_empty), 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule